// File: doc/BRIEF.md
# MII Management Master

This block drives clause-22 management frames from a host register interface onto the two-wire PHY management bus. Software programs a control register with the management clock divisor and a preamble-suppression choice. For a write it then loads the 16-bit data register. Writing a command word that carries a read or write request, a 5-bit PHY address and a 5-bit register address starts the frame.

While the frame is on the wire a status flag reads as busy. Commands that arrive during that time are dropped. When the flag clears after a read, the data register holds the 16 bits the PHY returned. A soft-reset strobe in the control register aborts any frame in flight and releases the bus.

The management clock is the system clock divided by a programmable integer, so a 100 MHz system clock with a divisor of 40 gives 2.5 MHz. The data line is driven through an output and an output enable, and an external pad merges these with the input.

Top module: `mdio_master`

## Requirements
- R1: After reset, status, data and control registers read 0, `mdc` is low and `mdio_oe` is low.
- R2: The register map is: command at address 0, data at address 1, status at address 2, control at address 3. In the command word, bit 15 requests a read and bit 14 requests a write (read wins if both are set), bits 9:5 are the PHY address and bits 4:0 are the register address. With preamble enabled, a frame is 32 ones followed by start bits 01, opcode (10 read, 01 write), PHY address, register address, two turnaround bits and 16 data bits. Each field is sent MSB first, one bit per `mdc` period, and each bit is valid at the rising edge of `mdc`.
- R3: A write frame sends turnaround 10 followed by the data register value. `mdio_oe` stays high for the whole frame.
- R4: A read frame drives the first turnaround bit as 1 and holds `mdio_oe` low from the second turnaround bit to the end of the frame. It samples `mdio_i` at each rising `mdc` edge of the 16 data bits, MSB first. The result can be read from the data register once busy clears.
- R5: Status bit 0 is set in the cycle after a command is accepted and stays set for exactly (frame bits × divisor) system cycles.
- R6: Control bits 15:9 hold the divisor minus one, and the register reads back as written. One `mdc` period lasts the divisor in system cycles, with the high phase lasting divisor − floor(divisor/2) cycles. A field value of 0 acts as a divisor of 2.
- R7: Control bit 8 set removes the 32-bit preamble, so the frame is 32 bits long.
- R8: `mdio_o` changes only while `mdc` is low, and `mdc` stays low while idle.
- R9: A command written while busy is ignored: the frame in flight, its length and the data register are unaffected.
- R10: Writing control bit 0 as 1 aborts any frame. In the next cycle busy is clear, `mdc` is low and `mdio_oe` is low, no further `mdc` edges follow, and the bit is not stored.
- R11: A command word with neither request bit set does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data for `cpu_addr` (combinational) |
| mdio_i | input | 1 | Management data from pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data to pad |
| mdio_oe | output | 1 | Output enable for `mdio_o` |

## Verification
The hardest situations to reach are those where a bus event lands partway through a frame. A second command or a soft reset has to arrive while the shifter is mid-frame, and for a read the turnaround must hand over bus ownership on exactly the right bit. The bench times such events by counting system cycles from the accepting write, at divisors chosen so that the intrusion falls inside the preamble or the address field. A behavioural PHY counts `mdc` rising edges and places each data bit on `mdio_i` at the preceding falling edge. Because of this, a frame shifted by even one bit returns a visibly different data word.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the MII management master.
// Assumes a 32-bit host bus with word-granular register addresses.
package mdio_pkg;
    localparam int ADDR_W     = 2;
    localparam int BUS_W      = 32;
    localparam int FLD_W      = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRM_BITS   = 32;

    localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
    localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd3;

    localparam int CMD_RD_BIT   = 15;
    localparam int CMD_WR_BIT   = 14;
    localparam int CMD_PHY_LSB  = 5;
    localparam int CMD_REG_LSB  = 0;
    localparam int CTL_SRST_BIT = 0;
    localparam int CTL_NOPRE_BIT = 8;
    localparam int CTL_DIV_LSB  = 9;

    typedef struct packed {
        logic              rd;
        logic [FLD_W-1:0]  phy;
        logic [FLD_W-1:0]  rg;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;
endpackage

// File: rtl/mdio_regs.sv
// Host register file: command decode, data, status and control.
// Assumes single-cycle writes; reads are a combinational mux.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [BUS_W-1:0]    cpu_wdata,
    output logic [BUS_W-1:0]    cpu_rdata,
    input  logic                busy,
    input  logic                rd_done,
    input  logic [DATA_W-1:0]   rd_value,
    output logic                start,
    output mdio_req_t           req,
    output logic                soft_rst,
    output logic [DIV_W-1:0]    div_m1,
    output logic                no_pre
);
    logic [DATA_W-1:0] data_q;
    logic [DIV_W-1:0]  div_q;
    logic              nopre_q;
    logic              wr_cmd, wr_data, wr_ctrl;

    // Decode write strobes per register.
    always_comb begin
        wr_cmd  = cpu_we && (cpu_addr == A_CMD);
        wr_data = cpu_we && (cpu_addr == A_DATA);
        wr_ctrl = cpu_we && (cpu_addr == A_CTRL);
    end

    // Hold data and control; completed reads take priority on data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            div_q   <= '0;
            nopre_q <= 1'b0;
        end else begin
            if (rd_done)
                data_q <= rd_value;
            else if (wr_data)
                data_q <= cpu_wdata[DATA_W-1:0];
            if (wr_ctrl) begin
                div_q   <= cpu_wdata[CTL_DIV_LSB +: DIV_W];
                nopre_q <= cpu_wdata[CTL_NOPRE_BIT];
            end
        end
    end

    // Form the request and the start and abort pulses.
    always_comb begin
        start     = wr_cmd && !busy &&
                    (cpu_wdata[CMD_RD_BIT] || cpu_wdata[CMD_WR_BIT]);
        req.rd    = cpu_wdata[CMD_RD_BIT];
        req.phy   = cpu_wdata[CMD_PHY_LSB +: FLD_W];
        req.rg    = cpu_wdata[CMD_REG_LSB +: FLD_W];
        req.wdata = data_q;
        soft_rst  = wr_ctrl && cpu_wdata[CTL_SRST_BIT];
        div_m1    = div_q;
        no_pre    = nopre_q;
    end

    // Read-back mux.
    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            A_DATA:  cpu_rdata[DATA_W-1:0] = data_q;
            A_STAT:  cpu_rdata[0] = busy;
            A_CTRL: begin
                cpu_rdata[CTL_DIV_LSB +: DIV_W] = div_q;
                cpu_rdata[CTL_NOPRE_BIT]        = nopre_q;
            end
            default: cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_clkgen.sv
// Management clock divider. Runs only while run is high and parks mdc low.
// Low phase lasts floor(D/2) cycles and the high phase the rest.
// Pre-edge strobes fire in the cycle before mdc changes.
module mdio_clkgen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             mdc,
    output logic             rise_pre,
    output logic             fall_pre
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] dvs, half, cnt_q, cnt_nx;

    // Effective divisor (minimum 2), half point and next count.
    always_comb begin
        dvs = CW'(div_m1) + CW'(1);
        if (dvs < CW'(2))
            dvs = CW'(2);
        half     = dvs >> 1;
        cnt_nx   = (cnt_q >= dvs - CW'(1)) ? '0 : cnt_q + CW'(1);
        rise_pre = run && (cnt_nx == half);
        fall_pre = run && (cnt_nx == '0);
    end

    // Phase counter and registered clock output.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            cnt_q <= cnt_nx;
            mdc   <= (cnt_nx >= half);
        end
    end
endmodule

// File: rtl/mdio_engine.sv
// Frame shifter. Steps one bit per mdc period on the falling edge and
// samples read data on the rising edge. Output bit and enable are
// decoded from state that changes on the same clock edge as mdc falls.
module mdio_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_req_t         req,
    input  logic              no_pre,
    input  logic              soft_rst,
    input  logic              rise_pre,
    input  logic              fall_pre,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_value
);
    localparam int IDX_W = 7;
    localparam logic [4:0]       TOP    = 5'(FRM_BITS - 1);
    localparam logic [IDX_W-1:0] TA2_OF = IDX_W'(15);
    localparam logic [IDX_W-1:0] DAT_OF = IDX_W'(16);

    logic                 busy_q, rd_q;
    logic [IDX_W-1:0]     pre_q, last_q, idx_q, rel;
    logic [FRM_BITS-1:0]  frm_q;
    logic [DATA_W-1:0]    sh_q;
    logic                 at_last;

    // Decode the line from the current bit index.
    always_comb begin
        rel      = idx_q - pre_q;
        at_last  = (idx_q == last_q);
        busy     = busy_q;
        mdio_o   = (!busy_q || idx_q < pre_q) ? 1'b1 : frm_q[TOP - rel[4:0]];
        mdio_oe  = busy_q && !(rd_q && idx_q >= pre_q + TA2_OF);
        rd_done  = busy_q && fall_pre && at_last && rd_q && !soft_rst;
        rd_value = sh_q;
    end

    // Frame state: load on start, sample on rise, advance on fall.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            busy_q <= 1'b0;
            rd_q   <= 1'b0;
            pre_q  <= '0;
            last_q <= '0;
            idx_q  <= '0;
            frm_q  <= '0;
            sh_q   <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            rd_q   <= req.rd;
            pre_q  <= no_pre ? '0 : IDX_W'(PRE_BITS);
            last_q <= (no_pre ? '0 : IDX_W'(PRE_BITS)) + IDX_W'(FRM_BITS - 1);
            idx_q  <= '0;
            frm_q  <= {2'b01, req.rd ? 2'b10 : 2'b01, req.phy, req.rg,
                       req.rd ? 2'b11 : 2'b10,
                       req.rd ? {DATA_W{1'b1}} : req.wdata};
            sh_q   <= '0;
        end else if (busy_q) begin
            if (rise_pre && rd_q && idx_q >= pre_q + DAT_OF)
                sh_q <= {sh_q[DATA_W-2:0], mdio_i};
            if (fall_pre) begin
                if (at_last)
                    busy_q <= 1'b0;
                else
                    idx_q <= idx_q + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
// MII management master top: register file, clock divider and shifter.
// Assumes an external pad merges mdio_o/mdio_oe/mdio_i.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic              busy, start, soft_rst, no_pre, rd_done;
    logic              rise_pre, fall_pre, run;
    logic [DIV_W-1:0]  div_m1;
    logic [DATA_W-1:0] rd_value;
    mdio_req_t         req;

    // Divider runs only during a frame and stops at once on abort.
    always_comb run = busy && !soft_rst;

    mdio_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .busy(busy),
        .rd_done(rd_done), .rd_value(rd_value), .start(start), .req(req),
        .soft_rst(soft_rst), .div_m1(div_m1), .no_pre(no_pre)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run), .div_m1(div_m1),
        .mdc(mdc), .rise_pre(rise_pre), .fall_pre(fall_pre)
    );

    mdio_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .req(req), .no_pre(no_pre),
        .soft_rst(soft_rst), .rise_pre(rise_pre), .fall_pre(fall_pre),
        .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rd_done(rd_done), .rd_value(rd_value)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Protocol checker for mdio_master, attached by bind.
module mdio_master_chk
    import mdio_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_we,
    input logic [1:0]  cpu_addr,
    input logic [31:0] cpu_wdata,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R8
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R8
    mdio_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(mdio_o)) |-> !mdc);
    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == A_CMD && !busy &&
         (cpu_wdata[CMD_RD_BIT] || cpu_wdata[CMD_WR_BIT])) |=> busy);
    // R11
    no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == A_CMD && !busy &&
         !cpu_wdata[CMD_RD_BIT] && !cpu_wdata[CMD_WR_BIT]) |=> !busy);
    // R10
    soft_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == A_CTRL && cpu_wdata[CTL_SRST_BIT])
        |=> (!busy && !mdc && !mdio_oe));
    // R6
    mdc_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    import mdio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_addr = 2'd0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe;

    int n_chk = 0, n_bad = 0;
    logic cap_o [2048];
    logic cap_oe[2048];
    int   cap_n = 0;
    int   base = 0;
    int   pre_len = 32;
    logic [15:0] phy_val = '0;
    int   viol = 0;
    int   hi_cnt = 0, last_hi = 0;
    logic prev_o = 1'b1;

    always #2.5 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // PHY model: record line at mdc rise.
    always @(posedge mdc) begin
        if (cap_n < 2048) begin
            cap_o[cap_n]  = mdio_o;
            cap_oe[cap_n] = mdio_oe;
        end
        cap_n = cap_n + 1;
    end

    // PHY model: present read data after mdc falls.
    always @(negedge mdc) begin
        int k;
        k = cap_n - base;
        if (k >= pre_len + 16 && k < pre_len + 32)
            mdio_i <= phy_val[15 - (k - pre_len - 16)];
        else
            mdio_i <= 1'b1;
    end

    // Line monitor: output changes while mdc high, and mdc high-phase length.
    always @(negedge clk) begin
        if (mdio_o !== prev_o && mdc) viol = viol + 1;
        prev_o = mdio_o;
        if (mdc) hi_cnt = hi_cnt + 1;
        else if (hi_cnt > 0) begin last_hi = hi_cnt; hi_cnt = 0; end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = A_STAT;
    endtask

    task automatic bus_rd(logic [1:0] a, output logic [31:0] d);
        cpu_addr = a;
        #1 d = cpu_rdata;
        cpu_addr = A_STAT;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        cpu_addr = A_STAT;
        #1;
        while (cpu_rdata[0] && cyc < 5000) begin
            cyc++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic run_cmd(logic [31:0] cmd, output int cyc);
        base = cap_n;
        bus_wr(A_CMD, cmd);
        wait_idle(cyc);
    endtask

    function automatic logic [31:0] mk_cmd(bit rd, int phy, int rg);
        logic [31:0] c;
        c = '0;
        c[rd ? CMD_RD_BIT : CMD_WR_BIT] = 1'b1;
        c[9:5] = 5'(phy);
        c[4:0] = 5'(rg);
        return c;
    endfunction

    task automatic check_frame(string tag, bit rd, int phy, int rg,
                               logic [15:0] wd, bit nopre);
        int pl, bad;
        logic [31:0] vec;
        pl = nopre ? 0 : 32;
        vec = {2'b01, rd ? 2'b10 : 2'b01, 5'(phy), 5'(rg),
               rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : wd};
        chk({tag, " bit count"}, cap_n - base, pl + 32);
        bad = 0;
        for (int k = 0; k < pl + 32; k++) begin
            logic eo, eoe;
            if (k < pl) begin eo = 1'b1; eoe = 1'b1; end
            else begin
                eo  = vec[31 - (k - pl)];
                eoe = !(rd && (k - pl) >= 15);
            end
            if (cap_oe[base + k] !== eoe) bad++;
            else if (eoe && cap_o[base + k] !== eo) bad++;
        end
        chk({tag, " bad bits"}, bad, 0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(A_STAT, d); chk("R1 status", d, 0);
        bus_rd(A_DATA, d); chk("R1 data", d, 0);
        bus_rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        chk("R1 mdc", mdc, 0);
        chk("R1 oe", mdio_oe, 0);
    endtask

    task automatic t_write();
        int cyc;
        bus_wr(A_CTRL, 32'd3 << 9);
        bus_wr(A_DATA, 32'hA55A);
        pre_len = 32;
        run_cmd(mk_cmd(0, 5'h11, 5'h0A), cyc);
        chk("R5 write busy cycles", cyc, 64 * 4);
        check_frame("R2 R3 write", 0, 5'h11, 5'h0A, 16'hA55A, 0);
        chk("R6 high phase D=4", last_hi, 2);
    endtask

    task automatic t_read();
        int cyc;
        logic [31:0] d;
        phy_val = 16'hC3E1; pre_len = 32;
        run_cmd(mk_cmd(1, 3, 1), cyc);
        chk("R5 read busy cycles", cyc, 64 * 4);
        check_frame("R2 R4 read", 1, 3, 1, 16'h0, 0);
        bus_rd(A_DATA, d); chk("R4 read data", d, 32'hC3E1);
    endtask

    task automatic t_nopre();
        int cyc;
        logic [31:0] d;
        bus_wr(A_CTRL, (32'd3 << 9) | (32'd1 << 8));
        bus_rd(A_CTRL, d); chk("R7 ctrl readback", d, (32'd3 << 9) | (32'd1 << 8));
        phy_val = 16'h1234; pre_len = 0;
        run_cmd(mk_cmd(1, 5'h1F, 5'h10), cyc);
        chk("R7 short busy cycles", cyc, 32 * 4);
        check_frame("R7 short read", 1, 5'h1F, 5'h10, 16'h0, 1);
        bus_rd(A_DATA, d); chk("R7 read data", d, 32'h1234);
    endtask

    task automatic t_div();
        int cyc;
        logic [31:0] d;
        bus_wr(A_CTRL, 32'd4 << 9);
        bus_rd(A_CTRL, d); chk("R6 ctrl readback", d, 32'd4 << 9);
        bus_wr(A_DATA, 32'h0001);
        pre_len = 32;
        run_cmd(mk_cmd(0, 1, 2), cyc);
        chk("R6 busy cycles D=5", cyc, 64 * 5);
        chk("R6 high phase D=5", last_hi, 3);
        check_frame("R6 D=5 frame", 0, 1, 2, 16'h0001, 0);
        bus_wr(A_CTRL, 32'd0);
        run_cmd(mk_cmd(0, 2, 3), cyc);
        chk("R6 busy cycles field 0", cyc, 64 * 2);
        chk("R6 high phase D=2", last_hi, 1);
    endtask

    task automatic t_busy_ignore();
        int cyc;
        logic [31:0] d;
        bus_wr(A_CTRL, 32'd3 << 9);
        bus_wr(A_DATA, 32'h0F0F);
        phy_val = 16'hBEEF; pre_len = 32;
        base = cap_n;
        bus_wr(A_CMD, mk_cmd(0, 1, 2));
        repeat (20) @(negedge clk);
        bus_wr(A_CMD, mk_cmd(1, 5'h1F, 5'h1F));
        wait_idle(cyc);
        chk("R9 remaining cycles", cyc, 64 * 4 - 22);
        check_frame("R9 first frame kept", 0, 1, 2, 16'h0F0F, 0);
        bus_rd(A_DATA, d); chk("R9 data untouched", d, 32'h0F0F);
    endtask

    task automatic t_none();
        int c0;
        logic [31:0] d;
        c0 = cap_n;
        bus_wr(A_CMD, (32'd3 << 5) | 32'd4);
        #1 chk("R11 not busy", cpu_rdata[0], 0);
        repeat (10) @(negedge clk);
        bus_rd(A_STAT, d); chk("R11 still idle", d, 0);
        chk("R11 no mdc edges", cap_n - c0, 0);
    endtask

    task automatic t_srst();
        int c0, cyc;
        logic [31:0] d;
        bus_wr(A_CTRL, 32'd3 << 9);
        bus_wr(A_DATA, 32'h5A5A);
        pre_len = 32;
        base = cap_n;
        bus_wr(A_CMD, mk_cmd(0, 4, 5));
        repeat (40) @(negedge clk);
        bus_wr(A_CTRL, (32'd3 << 9) | 32'd1);
        #1;
        chk("R10 busy cleared", cpu_rdata[0], 0);
        chk("R10 mdc low", mdc, 0);
        chk("R10 oe low", mdio_oe, 0);
        bus_rd(A_CTRL, d); chk("R10 strobe not stored", d, 32'd3 << 9);
        c0 = cap_n;
        repeat (20) @(negedge clk);
        chk("R10 no edges after abort", cap_n - c0, 0);
        run_cmd(mk_cmd(0, 6, 7), cyc);
        chk("R10 next frame cycles", cyc, 64 * 4);
        check_frame("R10 next frame", 0, 6, 7, 16'h5A5A, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_nopre();
        t_div();
        t_busy_ignore();
        t_none();
        t_srst();
        chk("R8 changes while mdc high", viol, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule